// File: doc/BRIEF.md
# Minimum-Extent Neighbourhood Selector

This block is the decision stage of an edge-preserving smoothing filter for a pixel stream. A 5x5 window around each centre pixel is covered by nine overlapping 3x3 sub-windows, labelled A to I by their centres. An upstream stage supplies, for each sub-window, its extent (maximum minus minimum intensity) and the sum of its nine pixels. This block picks the flattest sub-window, meaning the one with the smallest extent. It then outputs that sub-window's rounded average as the new value of the centre pixel. Picking a window that does not straddle an edge smooths noise without blurring contours.

The choice is made by a two-level tree of three-way comparators. Each comparator forwards the smallest extent of its three inputs together with the sum that belongs to it. A register sits between the two levels, so one sample can enter on every clock and the selection fits within one pixel period. The first level and the second level with the divide-by-nine each take one clock.

Top module: `nbhd_min_extent_sel`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `pix_o` is 0.
- R2: `out_valid` equals `in_valid` as sampled exactly two rising clock edges earlier.
- R3: Sub-window k (A=0, B=1, C=2, D=3, E=4, F=5, G=6, H=7, I=8) takes its extent from `ext_i[k*EXT_W +: EXT_W]` and its sum from `sum_i[k*SUM_W +: SUM_W]`. The output pixel is derived from the sum of the sub-window with the smallest extent.
- R4: The first level compares the groups (A,E,B), (H,I,F) and (D,G,C). When extents within a group are equal, the member listed earlier wins.
- R5: When group winners have equal extents, the earlier group in the order (A,E,B), (H,I,F), (D,G,C) wins. Overall, ties resolve in the order A,E,B,H,I,F,D,G,C.
- R6: The output pixel is floor((sum+4)/9), that is, the sum divided by nine and rounded to nearest. It saturates at 255 when this exceeds 255.
- R7: A cycle with `in_valid` low produces no output. In the cycle where its output would appear, `pix_o` keeps its previous value.
- R8: Samples presented on consecutive cycles are each processed independently, with no interaction between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | The nine pairs on the inputs are a sample |
| ext_i | input | 9*EXT_W (72) | Extents of sub-windows A..I, A in the lowest slice |
| sum_i | input | 9*SUM_W (108) | Sums of sub-windows A..I, A in the lowest slice |
| out_valid | output | 1 | `pix_o` carries a new smoothed pixel |
| pix_o | output | PIX_W (8) | Smoothed centre pixel |

## Verification
The bench builds the block with its defaults: 8-bit extents, 12-bit sums and an 8-bit pixel. A 12-bit sum can exceed the 2295 that nine 8-bit pixels produce, so the saturation at 255 can be reached. Random extents are drawn from a range of six values, which makes ties within a group and across groups frequent. This exercises the tie-breaking order alongside directed cases that make each of the nine sub-windows the unique minimum in turn.

// File: rtl/nbsel_pkg.sv
package nbsel_pkg;

    localparam int NUM_NB   = 9;
    localparam int GRP_SIZE = 3;
    localparam int NUM_GRP  = NUM_NB / GRP_SIZE;

    // Sub-window index (A=0 .. I=8) of member s in first-level group g.
    // The order within a group is the tie-break priority.
    function automatic int member(input int g, input int s);
        int idx;
        case (g * GRP_SIZE + s)
            0: idx = 0;  // A
            1: idx = 4;  // E
            2: idx = 1;  // B
            3: idx = 7;  // H
            4: idx = 8;  // I
            5: idx = 5;  // F
            6: idx = 3;  // D
            7: idx = 6;  // G
            default: idx = 2;  // C
        endcase
        return idx;
    endfunction

endpackage

// File: rtl/min3_sel.sv
module min3_sel #(
    parameter int EXT_W = 8,
    parameter int SUM_W = 12
) (
    input  logic [EXT_W-1:0] ext_a,
    input  logic [SUM_W-1:0] sum_a,
    input  logic [EXT_W-1:0] ext_b,
    input  logic [SUM_W-1:0] sum_b,
    input  logic [EXT_W-1:0] ext_c,
    input  logic [SUM_W-1:0] sum_c,
    output logic [EXT_W-1:0] ext_o,
    output logic [SUM_W-1:0] sum_o
);

    logic pick_a;
    logic pick_b;

    always_comb begin
        pick_a = (ext_a <= ext_b) && (ext_a <= ext_c);
        pick_b = !pick_a && (ext_b <= ext_c);
        if (pick_a) begin
            ext_o = ext_a;
            sum_o = sum_a;
        end else if (pick_b) begin
            ext_o = ext_b;
            sum_o = sum_b;
        end else begin
            ext_o = ext_c;
            sum_o = sum_c;
        end
    end

    // R3
    always_comb begin
        min_bound_chk: assert ((ext_o <= ext_a) && (ext_o <= ext_b) && (ext_o <= ext_c))
            else $error("winner extent above an input extent");
    end

    // R4
    always_comb begin
        pair_match_chk: assert (((ext_o == ext_a) && (sum_o == sum_a)) ||
                                ((ext_o == ext_b) && (sum_o == sum_b)) ||
                                ((ext_o == ext_c) && (sum_o == sum_c)))
            else $error("forwarded sum does not belong to forwarded extent");
    end

endmodule

// File: rtl/mean_div9.sv
module mean_div9 #(
    parameter int SUM_W = 12,
    parameter int PIX_W = 8
) (
    input  logic [SUM_W-1:0] sum_i,
    output logic [PIX_W-1:0] pix_o
);

    localparam logic [SUM_W:0] PIX_MAX = (SUM_W+1)'((1 << PIX_W) - 1);

    logic [SUM_W:0] biased;
    logic [SUM_W:0] quot;
    logic           sat;

    always_comb begin
        biased = {1'b0, sum_i} + (SUM_W+1)'(4);
        quot   = biased / (SUM_W+1)'(9);
        sat    = quot > PIX_MAX;
        pix_o  = sat ? PIX_MAX[PIX_W-1:0] : quot[PIX_W-1:0];
    end

    // R6
    always_comb begin
        round_err_chk: assert (sat ||
                               ((int'(pix_o) * 9 <= int'(sum_i) + 4) &&
                                (int'(sum_i) <= int'(pix_o) * 9 + 4)))
            else $error("mean not within rounding distance of sum/9");
    end

endmodule

// File: rtl/nbhd_min_extent_sel.sv
module nbhd_min_extent_sel #(
    parameter int EXT_W = 8,
    parameter int SUM_W = 12,
    parameter int PIX_W = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 in_valid,
    input  logic [nbsel_pkg::NUM_NB*EXT_W-1:0]   ext_i,
    input  logic [nbsel_pkg::NUM_NB*SUM_W-1:0]   sum_i,
    output logic                                 out_valid,
    output logic [PIX_W-1:0]                     pix_o
);

    localparam int NG = nbsel_pkg::NUM_GRP;

    typedef struct packed {
        logic                       s1_valid;
        logic [NG-1:0][EXT_W-1:0]   g_ext;
        logic [NG-1:0][SUM_W-1:0]   g_sum;
        logic                       out_valid;
        logic [PIX_W-1:0]           pix;
    } pipe_t;

    pipe_t st_d;
    pipe_t st_q;

    logic [NG-1:0][EXT_W-1:0] grp_ext;
    logic [NG-1:0][SUM_W-1:0] grp_sum;
    logic [EXT_W-1:0]         fin_ext;
    logic [SUM_W-1:0]         fin_sum;
    logic [PIX_W-1:0]         mean_pix;

    // first level: one three-way comparator per group
    for (genvar g = 0; g < NG; g++) begin : g_grp
        localparam int M0 = nbsel_pkg::member(g, 0);
        localparam int M1 = nbsel_pkg::member(g, 1);
        localparam int M2 = nbsel_pkg::member(g, 2);
        min3_sel #(.EXT_W(EXT_W), .SUM_W(SUM_W)) u_cmp (
            .ext_a (ext_i[M0*EXT_W +: EXT_W]),
            .sum_a (sum_i[M0*SUM_W +: SUM_W]),
            .ext_b (ext_i[M1*EXT_W +: EXT_W]),
            .sum_b (sum_i[M1*SUM_W +: SUM_W]),
            .ext_c (ext_i[M2*EXT_W +: EXT_W]),
            .sum_c (sum_i[M2*SUM_W +: SUM_W]),
            .ext_o (grp_ext[g]),
            .sum_o (grp_sum[g])
        );
    end

    // second level: comparator across the registered group winners
    min3_sel #(.EXT_W(EXT_W), .SUM_W(SUM_W)) u_final (
        .ext_a (st_q.g_ext[0]),
        .sum_a (st_q.g_sum[0]),
        .ext_b (st_q.g_ext[1]),
        .sum_b (st_q.g_sum[1]),
        .ext_c (st_q.g_ext[2]),
        .sum_c (st_q.g_sum[2]),
        .ext_o (fin_ext),
        .sum_o (fin_sum)
    );

    mean_div9 #(.SUM_W(SUM_W), .PIX_W(PIX_W)) u_mean (
        .sum_i (fin_sum),
        .pix_o (mean_pix)
    );

    always_comb begin
        st_d           = st_q;
        st_d.s1_valid  = in_valid;
        if (in_valid) begin
            st_d.g_ext = grp_ext;
            st_d.g_sum = grp_sum;
        end
        st_d.out_valid = st_q.s1_valid;
        if (st_q.s1_valid) begin
            st_d.pix   = mean_pix;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.out_valid;
    assign pix_o     = st_q.pix;

    // cycles since reset release, saturating at 2, for the latency check
    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm_q <= '0;
        end else if (warm_q != 2'd2) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (out_valid == $past(in_valid, 2)))
        else $error("out_valid does not follow in_valid by two clocks");

    // R7
    hold_pix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.s1_valid |=> $stable(pix_o))
        else $error("pixel changed without a valid sample");

    // R5
    always_comb begin
        if (rst_n) begin
            final_min_chk: assert ((fin_ext <= st_q.g_ext[0]) &&
                                   (fin_ext <= st_q.g_ext[1]) &&
                                   (fin_ext <= st_q.g_ext[2]))
                else $error("final winner above a group winner");
        end
    end

endmodule

// File: tb/nbhd_min_extent_sel_tb.sv
module nbhd_min_extent_sel_tb;

    localparam int EXT_W = 8;
    localparam int SUM_W = 12;
    localparam int PIX_W = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic [9*EXT_W-1:0] ext_i = '0;
    logic [9*SUM_W-1:0] sum_i = '0;
    logic               out_valid;
    logic [PIX_W-1:0]   pix_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    nbhd_min_extent_sel #(.EXT_W(EXT_W), .SUM_W(SUM_W), .PIX_W(PIX_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .ext_i     (ext_i),
        .sum_i     (sum_i),
        .out_valid (out_valid),
        .pix_o     (pix_o)
    );

    // reference model state
    int    pend_v = 0, pend_p = 0;
    string pend_tag = "";
    int    m1_v = 0, m1_p = 0;
    string m1_tag = "";
    int    m2_v = 0, m2_p = 0;
    string m2_tag = "";

    function automatic int ref_pix();
        int ord[9] = '{0, 4, 1, 7, 8, 5, 3, 6, 2};
        int best = ord[0];
        int q;
        for (int i = 1; i < 9; i++) begin
            if (ext_i[ord[i]*EXT_W +: EXT_W] < ext_i[best*EXT_W +: EXT_W]) best = ord[i];
        end
        q = (int'(sum_i[best*SUM_W +: SUM_W]) + 4) / 9;
        return (q > 255) ? 255 : q;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic fill(input int e, input int s);
        for (int k = 0; k < 9; k++) begin
            ext_i[k*EXT_W +: EXT_W] = EXT_W'(e);
            sum_i[k*SUM_W +: SUM_W] = SUM_W'(s + k * 40);
        end
    endtask

    task automatic set_nb(input int k, input int e, input int s);
        ext_i[k*EXT_W +: EXT_W] = EXT_W'(e);
        sum_i[k*SUM_W +: SUM_W] = SUM_W'(s);
    endtask

    // drive one sample, wait one clock, compare outputs with the model
    task automatic send(input bit v, input string tag);
        in_valid = v;
        pend_v   = v;
        pend_p   = ref_pix();
        pend_tag = tag;
        @(negedge clk);
        m2_v = m1_v;
        if (m1_v != 0) begin
            m2_p   = m1_p;
            m2_tag = m1_tag;
        end else begin
            m2_tag = "R7";
        end
        m1_v = pend_v; m1_p = pend_p; m1_tag = pend_tag;
        check(out_valid == m2_v[0], "R2 valid", int'(out_valid), m2_v);
        check(int'(pix_o) == m2_p, m2_tag, int'(pix_o), m2_p);
    endtask

    initial begin
        void'($urandom(32'd2024));
        // R1: reset holds outputs low even with valid inputs
        fill(3, 500);
        in_valid = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
            check(pix_o == '0, "R1 pix", int'(pix_o), 0);
        end
        in_valid = 1'b0;
        rst_n = 1'b1;
        send(1'b0, "R1 idle");

        // R3: each sub-window in turn is the unique minimum
        for (int k = 0; k < 9; k++) begin
            fill(20, 100);
            set_nb(k, 2, 90 * (k + 1) + 3);
            send(1'b1, "R3 unique min");
        end
        // R4: tie inside a group, E and B equal and lowest -> E
        fill(30, 200);
        set_nb(4, 5, 450); set_nb(1, 5, 1800);
        send(1'b1, "R4 E before B");
        // R4: tie of I and F -> I
        fill(30, 200);
        set_nb(5, 1, 900); set_nb(8, 1, 1350);
        send(1'b1, "R4 I before F");
        // R5: all equal -> A
        fill(7, 63);
        send(1'b1, "R5 all equal");
        // R5: tie across groups, D and H lowest -> H
        fill(30, 200);
        set_nb(3, 4, 1000); set_nb(7, 4, 2000);
        send(1'b1, "R5 H before D");
        // R5: tie of G and B -> B
        fill(30, 200);
        set_nb(6, 0, 300); set_nb(1, 0, 2250);
        send(1'b1, "R5 B before G");
        // R6: rounding edges and saturation
        fill(9, 0); set_nb(0, 0, 13);   send(1'b1, "R6 round down");
        fill(9, 0); set_nb(0, 0, 14);   send(1'b1, "R6 round up");
        fill(9, 0); set_nb(0, 0, 2295); send(1'b1, "R6 max pixel");
        fill(9, 0); set_nb(0, 0, 4095); send(1'b1, "R6 saturate");
        fill(9, 0); set_nb(0, 0, 0);    send(1'b1, "R6 zero");
        // R7: invalid samples with changing data must not disturb the pixel
        fill(1, 1000); set_nb(2, 0, 2000);
        send(1'b1, "R7 before gap");
        fill(0, 3000);
        send(1'b0, "R7 gap");
        send(1'b0, "R7 gap");
        send(1'b0, "R7 gap");
        // R8: random back-to-back stream with frequent ties
        for (int n = 0; n < 400; n++) begin
            for (int k = 0; k < 9; k++) begin
                set_nb(k, int'($urandom % 6), int'($urandom % 4096));
            end
            send(($urandom % 4) != 0, "R8 stream");
        end
        send(1'b0, "R8 drain");
        send(1'b0, "R8 drain");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule